// File: doc/BRIEF.md
# Graphics Master Request Router

This block sits behind the target side of a graphics port and receives one request descriptor per handshake. A descriptor holds a 4-bit command, an address, a length in quadwords and eight byte enables. The block decodes the command and checks the address against a programmable main-memory window. Depending on the result, it queues the request for the memory controller, answers it locally on a read-return channel, or accepts it and discards it without any response.

Two queues feed the memory port. The high-priority queue holds high-priority reads and writes. The low-priority queue holds low-priority reads, low-priority writes and ordering markers (fences), all in arrival order. One issue register presents entries to the memory port, and a pending high-priority entry is always chosen before a low-priority one. A separate completion engine streams filler quadwords for reads that target space outside the window and for flush commands.

Two state machines control the block. The issue stage has the states `IS_EMPTY` (nothing presented) and `IS_HOLD` (an entry presented until `mem_ready`). It moves from `IS_EMPTY` to `IS_HOLD` when either queue has an entry. It reloads while in `IS_HOLD` on each accepted beat, and it returns to `IS_EMPTY` when a beat is accepted and both queues are empty. The completion engine has the states `LC_IDLE` and `LC_STREAM`. It moves from `LC_IDLE` to `LC_STREAM` when it accepts a local job, and it moves from `LC_STREAM` to `LC_IDLE` after the final beat.

Top module: `agp_req_router`

## Requirements
- R1: Only the command codes 0000, 0001, 0100, 0101, 1000, 1001, 1010 and 1100 have an effect. Any other code is accepted (`req_ready`=1) and produces no memory beat and no return beat.
- R2: An address is in main memory when `ap_base` <= address <= `ap_limit`, with both bounds included. Any other address counts as hub space.
- R3: For addresses in main memory, reads (0000 low, 1000 low, 0001 high, 1001 high) and writes (0100 low, 0101 high) produce exactly one memory beat. That beat carries the request's address, length and byte enables, with `mem_write` set for writes and `mem_hipri` set for the high-priority codes.
- R4: A write (0100 or 0101) to hub space produces one memory beat with `mem_write`=1 and the request's priority, and with `mem_be`=0. It produces no return beats.
- R5: A read (0000, 0001, 1000, 1001) to hub space produces no memory beat. Instead it produces `req_len`+1 return beats. `ret_hipri`=1 for codes 0001 and 1001, and 0 for codes 0000 and 1000.
- R6: A flush (1010) produces exactly one low-priority return beat and no memory beat, whatever its address and length.
- R7: A fence (1100) produces one memory beat with `mem_fence`=1, `mem_write`=0 and `mem_hipri`=0, and it produces no return beat.
- R8: Every memory beat that is not a fence has `mem_nosnoop`=1, and a fence beat has `mem_nosnoop`=0.
- R9: When both queues hold entries, the next issued beat comes from the high-priority queue. Low-priority beats, fences included, are issued in arrival order. A beat already presented is not replaced.
- R10: Each queue holds 8 entries, in addition to the one entry presented at the memory port. `req_ready` is 0 for a request whose target queue is full, and a full low queue does not block the high queue.
- R11: While `mem_valid`=1 and `mem_ready`=0, the presented beat stays unchanged in the following cycle.
- R12: Every return beat carries all-ones data. `ret_last` is 1 only on the final beat of each local completion, and `ret_valid` is 0 in the cycle after a final beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ap_base | input | 32 | Lowest main-memory address |
| ap_limit | input | 32 | Highest main-memory address |
| req_valid | input | 1 | Request descriptor valid |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_cmd | input | 4 | Command code |
| req_addr | input | 32 | Request address |
| req_len | input | 3 | Length in quadwords minus one |
| req_be | input | 8 | Byte enables |
| mem_valid | output | 1 | Memory beat presented |
| mem_ready | input | 1 | Memory port takes the beat |
| mem_write | output | 1 | Beat is a write |
| mem_hipri | output | 1 | Beat is high priority |
| mem_fence | output | 1 | Beat is an ordering marker |
| mem_nosnoop | output | 1 | Beat needs no coherency action |
| mem_addr | output | 32 | Beat address |
| mem_len | output | 3 | Beat length in quadwords minus one |
| mem_be | output | 8 | Beat byte enables |
| ret_valid | output | 1 | Return beat valid |
| ret_hipri | output | 1 | Return beat belongs to a high-priority request |
| ret_last | output | 1 | Final beat of a local completion |
| ret_data | output | 64 | Return data |

## Verification
The case that needs care is a high-priority entry and low-priority entries, fence included, all waiting at the memory port in the same cycle. The bench creates it by holding `mem_ready` low while it queues a low write, a fence, a low read and then a high write. While `mem_ready` is still low it compares the presented beat across cycles. It then releases `mem_ready` and checks the issued order against a sequence derived from R9. A second overlap is filling the low queue while the high queue keeps accepting requests. The bench judges this from `req_ready` and from the drained beat count.

// File: rtl/agp_rt_pkg.sv
package agp_rt_pkg;

    localparam logic [3:0] CMD_RD_LO  = 4'b0000;
    localparam logic [3:0] CMD_RD_HI  = 4'b0001;
    localparam logic [3:0] CMD_WR_LO  = 4'b0100;
    localparam logic [3:0] CMD_WR_HI  = 4'b0101;
    localparam logic [3:0] CMD_LRD_LO = 4'b1000;
    localparam logic [3:0] CMD_LRD_HI = 4'b1001;
    localparam logic [3:0] CMD_FLUSH  = 4'b1010;
    localparam logic [3:0] CMD_FENCE  = 4'b1100;

    typedef enum logic [1:0] {
        ACT_DROP,
        ACT_QLO,
        ACT_QHI,
        ACT_LOCAL
    } act_e;

    typedef struct packed {
        logic write;
        logic hipri;
        logic fence;
        logic nosnoop;
    } flags_t;

    localparam int FLAG_W = $bits(flags_t);

endpackage

// File: rtl/agp_cmd_decode.sv
module agp_cmd_decode
    import agp_rt_pkg::*;
#(
    parameter int AW = 32,
    parameter int BW = 8
) (
    input  logic [3:0]    cmd,
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] ap_base,
    input  logic [AW-1:0] ap_limit,
    input  logic [BW-1:0] be_in,
    output act_e          act,
    output flags_t        flg,
    output logic [BW-1:0] be_out,
    output logic          loc_hi,
    output logic          loc_one
);

    logic in_mem;
    assign in_mem = (addr >= ap_base) && (addr <= ap_limit);

    always_comb begin
        act     = ACT_DROP;
        flg     = '0;
        be_out  = be_in;
        loc_hi  = 1'b0;
        loc_one = 1'b0;
        case (cmd)
            CMD_RD_LO, CMD_LRD_LO: begin
                if (in_mem) begin
                    act         = ACT_QLO;
                    flg.nosnoop = 1'b1;
                end else begin
                    act = ACT_LOCAL;
                end
            end
            CMD_RD_HI, CMD_LRD_HI: begin
                if (in_mem) begin
                    act         = ACT_QHI;
                    flg.hipri   = 1'b1;
                    flg.nosnoop = 1'b1;
                end else begin
                    act    = ACT_LOCAL;
                    loc_hi = 1'b1;
                end
            end
            CMD_WR_LO, CMD_WR_HI: begin
                act         = (cmd == CMD_WR_HI) ? ACT_QHI : ACT_QLO;
                flg.write   = 1'b1;
                flg.hipri   = (cmd == CMD_WR_HI);
                flg.nosnoop = 1'b1;
                if (!in_mem) be_out = '0;
            end
            CMD_FLUSH: begin
                act     = ACT_LOCAL;
                loc_one = 1'b1;
            end
            CMD_FENCE: begin
                act       = ACT_QLO;
                flg.fence = 1'b1;
            end
            default: act = ACT_DROP;
        endcase
    end

endmodule

// File: rtl/agp_req_fifo.sv
module agp_req_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LASTP = PW'(DEPTH - 1);

    logic [W-1:0]  store [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt;

    assign full  = (cnt == CW'(DEPTH));
    assign empty = (cnt == '0);
    assign dout  = store[rd_ptr];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == LASTP) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == LASTP) ? '0 : rd_ptr + 1'b1;
            if (push && !pop)      cnt <= cnt + 1'b1;
            else if (pop && !push) cnt <= cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push) store[wr_ptr] <= din;
    end

    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // R10
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

endmodule

// File: rtl/agp_mem_issue.sv
module agp_mem_issue #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         lo_empty,
    input  logic [W-1:0] lo_dout,
    input  logic         hi_empty,
    input  logic [W-1:0] hi_dout,
    input  logic         mem_ready,
    output logic         lo_pop,
    output logic         hi_pop,
    output logic         mem_valid,
    output logic [W-1:0] held
);

    typedef enum logic {IS_EMPTY, IS_HOLD} is_state_e;

    is_state_e state, state_n;
    logic      load, avail;

    assign avail = !lo_empty || !hi_empty;

    always_comb begin
        state_n = state;
        load    = 1'b0;
        unique case (state)
            IS_EMPTY: begin
                load = 1'b1;
                if (avail) state_n = IS_HOLD;
            end
            IS_HOLD: begin
                if (mem_ready) begin
                    load    = 1'b1;
                    state_n = avail ? IS_HOLD : IS_EMPTY;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= IS_EMPTY;
        else        state <= state_n;
    end

    always_comb begin
        hi_pop    = load && !hi_empty;
        lo_pop    = load && hi_empty && !lo_empty;
        mem_valid = (state == IS_HOLD);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      held <= '0;
        else if (hi_pop) held <= hi_dout;
        else if (lo_pop) held <= lo_dout;
    end

    // R11
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(held));

    // R9
    pick_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lo_pop |-> hi_empty);

endmodule

// File: rtl/agp_local_cpl.sv
module agp_local_cpl #(
    parameter int          LW   = 3,
    parameter int          DW   = 64,
    parameter logic [DW-1:0] FILL = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [LW-1:0] start_len,
    input  logic          start_hi,
    input  logic          start_one,
    output logic          idle,
    output logic          ret_valid,
    output logic          ret_hipri,
    output logic          ret_last,
    output logic [DW-1:0] ret_data
);

    typedef enum logic {LC_IDLE, LC_STREAM} lc_state_e;

    lc_state_e     state, state_n;
    logic [LW-1:0] cnt;
    logic          hi_q;

    always_comb begin
        state_n = state;
        unique case (state)
            LC_IDLE:   if (start) state_n = LC_STREAM;
            LC_STREAM: if (cnt == '0) state_n = LC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= LC_IDLE;
        else        state <= state_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            hi_q <= 1'b0;
        end else if (state == LC_IDLE && start) begin
            cnt  <= start_one ? '0 : start_len;
            hi_q <= start_hi;
        end else if (state == LC_STREAM && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    always_comb begin
        idle      = (state == LC_IDLE);
        ret_valid = (state == LC_STREAM);
        ret_hipri = ret_valid && hi_q;
        ret_last  = ret_valid && (cnt == '0);
        ret_data  = ret_valid ? FILL : '0;
    end

    // R12
    gap_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ret_last |=> !ret_valid);

    // R5
    prio_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid && !ret_last |=> ret_valid && $stable(ret_hipri));

endmodule

// File: rtl/agp_req_router.sv
module agp_req_router
    import agp_rt_pkg::*;
#(
    parameter int AW    = 32,
    parameter int LW    = 3,
    parameter int BW    = 8,
    parameter int DW    = 64,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ap_base,
    input  logic [AW-1:0] ap_limit,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [3:0]    req_cmd,
    input  logic [AW-1:0] req_addr,
    input  logic [LW-1:0] req_len,
    input  logic [BW-1:0] req_be,
    output logic          mem_valid,
    input  logic          mem_ready,
    output logic          mem_write,
    output logic          mem_hipri,
    output logic          mem_fence,
    output logic          mem_nosnoop,
    output logic [AW-1:0] mem_addr,
    output logic [LW-1:0] mem_len,
    output logic [BW-1:0] mem_be,
    output logic          ret_valid,
    output logic          ret_hipri,
    output logic          ret_last,
    output logic [DW-1:0] ret_data
);

    localparam int EW = FLAG_W + AW + LW + BW;

    act_e          act;
    flags_t        flg, mflg;
    logic [BW-1:0] be_dec;
    logic          loc_hi, loc_one;
    logic          accept, lo_push, hi_push, lc_start, lc_idle;
    logic          lo_full, lo_empty, hi_full, hi_empty, lo_pop, hi_pop;
    logic [EW-1:0] entry, lo_dout, hi_dout, held;
    logic          is_rsvd;

    agp_cmd_decode #(.AW(AW), .BW(BW)) u_dec (
        .cmd(req_cmd), .addr(req_addr), .ap_base(ap_base), .ap_limit(ap_limit),
        .be_in(req_be), .act(act), .flg(flg), .be_out(be_dec),
        .loc_hi(loc_hi), .loc_one(loc_one)
    );

    always_comb begin
        unique case (act)
            ACT_DROP:  req_ready = 1'b1;
            ACT_QLO:   req_ready = !lo_full;
            ACT_QHI:   req_ready = !hi_full;
            ACT_LOCAL: req_ready = lc_idle;
        endcase
    end

    assign accept   = req_valid && req_ready;
    assign lo_push  = accept && (act == ACT_QLO);
    assign hi_push  = accept && (act == ACT_QHI);
    assign lc_start = accept && (act == ACT_LOCAL);
    assign entry    = {flg, req_addr, req_len, be_dec};

    agp_req_fifo #(.W(EW), .DEPTH(DEPTH)) u_qlo (
        .clk(clk), .rst_n(rst_n), .push(lo_push), .din(entry), .pop(lo_pop),
        .dout(lo_dout), .full(lo_full), .empty(lo_empty)
    );

    agp_req_fifo #(.W(EW), .DEPTH(DEPTH)) u_qhi (
        .clk(clk), .rst_n(rst_n), .push(hi_push), .din(entry), .pop(hi_pop),
        .dout(hi_dout), .full(hi_full), .empty(hi_empty)
    );

    agp_mem_issue #(.W(EW)) u_issue (
        .clk(clk), .rst_n(rst_n), .lo_empty(lo_empty), .lo_dout(lo_dout),
        .hi_empty(hi_empty), .hi_dout(hi_dout), .mem_ready(mem_ready),
        .lo_pop(lo_pop), .hi_pop(hi_pop), .mem_valid(mem_valid), .held(held)
    );

    assign {mflg, mem_addr, mem_len, mem_be} = held;
    assign mem_write   = mflg.write;
    assign mem_hipri   = mflg.hipri;
    assign mem_fence   = mflg.fence;
    assign mem_nosnoop = mflg.nosnoop;

    agp_local_cpl #(.LW(LW), .DW(DW), .FILL('1)) u_lcpl (
        .clk(clk), .rst_n(rst_n), .start(lc_start), .start_len(req_len),
        .start_hi(loc_hi), .start_one(loc_one), .idle(lc_idle),
        .ret_valid(ret_valid), .ret_hipri(ret_hipri), .ret_last(ret_last),
        .ret_data(ret_data)
    );

    assign is_rsvd = !(req_cmd inside {CMD_RD_LO, CMD_RD_HI, CMD_WR_LO, CMD_WR_HI,
                                       CMD_LRD_LO, CMD_LRD_HI, CMD_FLUSH, CMD_FENCE});

    // R1
    reserved_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && is_rsvd |-> req_ready && !lo_push && !hi_push && !lc_start);

    // R7
    fence_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && mem_fence |-> !mem_hipri && !mem_write);

    // R8
    nosnoop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (mem_nosnoop != mem_fence));

endmodule

// File: tb/tb_agp_req_router.sv
`timescale 1ns/1ps
module tb_agp_req_router;

    localparam logic [31:0] BASE  = 32'h0000_1000;
    localparam logic [31:0] LIMIT = 32'h0000_1FFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [3:0]  req_cmd = '0;
    logic [31:0] req_addr = '0;
    logic [2:0]  req_len = '0;
    logic [7:0]  req_be = '0;
    logic        mem_valid, mem_ready = 1'b1;
    logic        mem_write, mem_hipri, mem_fence, mem_nosnoop;
    logic [31:0] mem_addr;
    logic [2:0]  mem_len;
    logic [7:0]  mem_be;
    logic        ret_valid, ret_hipri, ret_last;
    logic [63:0] ret_data;

    always #2 clk = ~clk;

    agp_req_router dut (
        .clk(clk), .rst_n(rst_n), .ap_base(BASE), .ap_limit(LIMIT),
        .req_valid(req_valid), .req_ready(req_ready), .req_cmd(req_cmd),
        .req_addr(req_addr), .req_len(req_len), .req_be(req_be),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
        .mem_hipri(mem_hipri), .mem_fence(mem_fence), .mem_nosnoop(mem_nosnoop),
        .mem_addr(mem_addr), .mem_len(mem_len), .mem_be(mem_be),
        .ret_valid(ret_valid), .ret_hipri(ret_hipri), .ret_last(ret_last),
        .ret_data(ret_data)
    );

    int errors = 0;
    int checks = 0;

    int          mn = 0, rn = 0;
    logic [31:0] ml_addr [64];
    logic [2:0]  ml_len  [64];
    logic [7:0]  ml_be   [64];
    bit          ml_w [64], ml_h [64], ml_f [64], ml_ns [64];
    bit          rl_h [64], rl_l [64];
    logic [63:0] rl_d [64];

    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_valid && mem_ready && mn < 64) begin
                ml_addr[mn] = mem_addr; ml_len[mn] = mem_len; ml_be[mn] = mem_be;
                ml_w[mn] = mem_write; ml_h[mn] = mem_hipri;
                ml_f[mn] = mem_fence; ml_ns[mn] = mem_nosnoop;
                mn++;
            end
            if (ret_valid && rn < 64) begin
                rl_h[rn] = ret_hipri; rl_l[rn] = ret_last; rl_d[rn] = ret_data;
                rn++;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [3:0] c, input logic [31:0] a, input logic [2:0] l,
                        input logic [7:0] b, output bit took);
        @(posedge clk); #1;
        req_valid = 1'b1; req_cmd = c; req_addr = a; req_len = l; req_be = b;
        took = 1'b0;
        for (int i = 0; i < 12 && !took; i++) begin
            @(negedge clk);
            if (req_ready) took = 1'b1;
            @(posedge clk); #1;
        end
        req_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    initial begin
        #(4 * 150000);
        errors++; checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        bit took;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk(!mem_valid && !ret_valid, "reset idle outputs", {mem_valid, ret_valid}, 0);

        // Sweep every command against both aperture edges, inside and outside (R1..R8, R12)
        for (int c = 0; c < 16; c++) begin
            for (int ai = 0; ai < 4; ai++) begin
                logic [31:0] a;
                logic [2:0]  l;
                logic [7:0]  b;
                bit in_m, e_mem, e_w, e_h, e_f, e_rh;
                int e_ret;
                logic [7:0] e_be;
                bit ok_h, ok_d, ok_l;
                a = (ai == 0) ? BASE : (ai == 1) ? LIMIT : (ai == 2) ? BASE - 1 : LIMIT + 1;
                l = 3'((c + ai * 3) % 8);
                b = 8'(8'hA5 ^ c ^ (ai << 4));
                in_m = (ai < 2);
                e_mem = 0; e_w = 0; e_h = 0; e_f = 0; e_ret = 0; e_rh = 0; e_be = b;
                case (c)
                    0, 8: if (in_m) e_mem = 1; else e_ret = l + 1;
                    1, 9: if (in_m) begin e_mem = 1; e_h = 1; end
                          else begin e_ret = l + 1; e_rh = 1; end
                    4, 5: begin
                        e_mem = 1; e_w = 1; e_h = (c == 5);
                        if (!in_m) e_be = 8'h00;
                    end
                    10: e_ret = 1;
                    12: begin e_mem = 1; e_f = 1; end
                    default: ;
                endcase
                mn = 0; rn = 0;
                send(4'(c), a, l, b, took);
                idle(14);
                // R1: every code is accepted
                chk(took, $sformatf("R1 accept cmd=%0d", c), took, 1);
                // R2 R3 R4 R7: memory beat presence
                chk(mn == int'(e_mem), $sformatf("R2 R3 mem beats cmd=%0d ai=%0d", c, ai), mn, e_mem);
                if (e_mem && mn == 1) begin
                    chk(ml_w[0] == e_w && ml_h[0] == e_h && ml_f[0] == e_f,
                        $sformatf("R3 R4 R7 kind cmd=%0d ai=%0d", c, ai),
                        {ml_w[0], ml_h[0], ml_f[0]}, {e_w, e_h, e_f});
                    chk(ml_addr[0] == a && ml_len[0] == l && ml_be[0] == e_be,
                        $sformatf("R3 R4 fields cmd=%0d ai=%0d", c, ai), ml_be[0], e_be);
                    // R8
                    chk(ml_ns[0] == !e_f, $sformatf("R8 nosnoop cmd=%0d", c), ml_ns[0], !e_f);
                end
                // R5 R6: return beat count
                chk(rn == e_ret, $sformatf("R5 R6 return beats cmd=%0d ai=%0d", c, ai), rn, e_ret);
                if (e_ret > 0 && rn == e_ret) begin
                    ok_h = 1; ok_d = 1; ok_l = 1;
                    for (int k = 0; k < rn; k++) begin
                        if (rl_h[k] != e_rh) ok_h = 0;
                        if (rl_d[k] != '1) ok_d = 0;
                        if (rl_l[k] != (k == rn - 1)) ok_l = 0;
                    end
                    chk(ok_h, $sformatf("R5 return priority cmd=%0d", c), ok_h, 1);
                    chk(ok_d && ok_l, $sformatf("R12 data/last cmd=%0d", c), {ok_d, ok_l}, 2'b11);
                end
            end
        end

        // Ordering with high and low entries waiting together (R9, R11)
        begin
            logic [31:0] a0;
            mem_ready = 1'b0; mn = 0; rn = 0;
            send(4'b0100, BASE + 32'h10, 3'd0, 8'hFF, took);
            send(4'b1100, BASE + 32'h20, 3'd0, 8'h00, took);
            send(4'b0000, BASE + 32'h30, 3'd1, 8'h0F, took);
            send(4'b0101, BASE + 32'h40, 3'd2, 8'hF0, took);
            @(negedge clk); a0 = mem_addr;
            idle(2); @(negedge clk);
            // R11
            chk(mem_valid && mem_addr == a0 && a0 == BASE + 32'h10,
                "R11 held beat stable", mem_addr, BASE + 32'h10);
            @(posedge clk); #1; mem_ready = 1'b1;
            idle(10);
            chk(mn == 4, "R9 drained count", mn, 4);
            chk(ml_addr[0] == BASE + 32'h10, "R9 held low first", ml_addr[0], BASE + 32'h10);
            chk(ml_addr[1] == BASE + 32'h40 && ml_h[1], "R9 high bypasses", ml_addr[1], BASE + 32'h40);
            chk(ml_addr[2] == BASE + 32'h20 && ml_f[2], "R9 fence in order", ml_addr[2], BASE + 32'h20);
            chk(ml_addr[3] == BASE + 32'h30, "R9 low read after fence", ml_addr[3], BASE + 32'h30);
        end

        // Capacity (R10)
        begin
            int acc;
            bit hi_took;
            mem_ready = 1'b0; mn = 0; acc = 0;
            for (int k = 0; k < 10; k++) begin
                send(4'b0100, BASE + 32'(k * 8), 3'd0, 8'h11, took);
                if (took) acc++;
            end
            chk(acc == 9, "R10 low queue capacity", acc, 9);
            @(negedge clk);
            chk(!req_ready || !req_valid, "R10 ready low when full", req_ready, 0);
            send(4'b0101, BASE + 32'h800, 3'd0, 8'h22, hi_took);
            chk(hi_took, "R10 high queue not blocked", hi_took, 1);
            @(posedge clk); #1; mem_ready = 1'b1;
            idle(20);
            chk(mn == 10, "R10 drained count", mn, 10);
            chk(ml_h[1] && ml_addr[1] == BASE + 32'h800, "R9 R10 high second", ml_addr[1], BASE + 32'h800);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule